// File: doc/BRIEF.md
# Secure Doorbell Mailbox

This unit carries doorbell notifications between an application processor and a system control processor. It has two secure channels, one for each direction. Channel 0 at base 0x200 carries notifications towards the application processor. Channel 1 at base 0x300 carries them towards the control processor.

Each channel keeps a 32-bit status word. Bits 30..0 are independent message slots. A sender raises a slot by writing a one to it through the channel's set offset (base+0x08). The receiver acknowledges a slot by writing a one to it through the clear offset (base+0x10). The status word itself is read at base+0x00.

Bit 31 of each status word is not a slot. It is a sticky flag that records an attempt to reach that channel's registers without the secure attribute. Each channel drives a level interrupt that is high while its status word is nonzero.

The register bus is a single-cycle access port. `busSel` qualifies an access and `busWrite` selects its direction. `busSecure` carries the security attribute of the access. Read data is combinational from the registers and is valid in the cycle of the access.

Top module: `mbox_doorbell`

## Requirements
- R1: After reset, both status words are zero, both interrupts are low, and secure status reads return 0.
- R2: A secure write to a channel's set offset (base+0x08) ORs write-data bits 30..0 into that channel's status. Zero bits leave their slots unchanged.
- R3: A secure write to a channel's clear offset (base+0x10) clears every status bit whose write-data bit is 1, and leaves the other bits unchanged.
- R4: Bit 31 of a set-offset write is ignored, so a set write never raises the flag bit. The slots 30..0 are all settable.
- R5: A non-secure write to any of a channel's three offsets leaves slots 30..0 unchanged and sets that channel's status bit 31.
- R6: A non-secure read of any channel offset returns 0 and sets that channel's status bit 31.
- R7: The flag bit 31 is cleared only by a secure write to the clear offset with write-data bit 31 set. Slot bits named in the same write are cleared in the same cycle.
- R8: Each interrupt (channel 0 → `irqToApp`, channel 1 → `irqToCtl`) is high exactly when its channel's status is nonzero. It changes at the clock edge that samples the write.
- R9: Reads of set and clear offsets return 0. Accesses to any address other than the six mapped offsets read 0 and change no state.
- R10: An access to one channel never changes the other channel's status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busSecure | input | 1 | 1 = secure access |
| busAddr | input | 12 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during a read access |
| irqToApp | output | 1 | Channel 0 status nonzero |
| irqToCtl | output | 1 | Channel 1 status nonzero |

## Verification
Two functions can land on one status word in the same cycle. The first is a secure clear write that names both the flag bit and slot bits. The bench provokes this by first setting slots 0 and 1, then raising the flag with a non-secure write, then issuing one clear of 0x8000_0001. It judges the result by reading back exactly 0x0000_0002 with the interrupt still high. The second is a set write of all ones, where slot raising and the ignored flag bit coincide. It must read back 0x7FFF_FFFF.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int NUM_CH = 2;

  typedef struct packed {
    logic [NUM_CH-1:0] setEn;   // secure write to set offset
    logic [NUM_CH-1:0] clrEn;   // secure write to clear offset
    logic [NUM_CH-1:0] nsHit;   // non-secure access to any channel offset
    logic [NUM_CH-1:0] rdStat;  // secure read of status offset
  } ctrlStrobes_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [11:0] CH_BASE   = 12'h200,
  parameter logic [11:0] CH_STRIDE = 12'h100
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busSecure,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strb
);
  localparam logic [ADDR_W-1:0] OFS_SET = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_CLR = ADDR_W'(8'h10);

  for (genvar c = 0; c < NUM_CH; c++) begin : gDec
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(CH_BASE + CH_STRIDE * c);
    logic hitStat, hitSet, hitClr, hitAny;
    assign hitStat = (busAddr == BASE);
    assign hitSet  = (busAddr == BASE + OFS_SET);
    assign hitClr  = (busAddr == BASE + OFS_CLR);
    assign hitAny  = hitStat | hitSet | hitClr;

    assign strb.setEn[c]  = busSel & busWrite & busSecure & hitSet;
    assign strb.clrEn[c]  = busSel & busWrite & busSecure & hitClr;
    assign strb.nsHit[c]  = busSel & ~busSecure & hitAny;
    assign strb.rdStat[c] = busSel & ~busWrite & busSecure & hitStat;
  end
endmodule

// File: rtl/mbox_dpath.sv
module mbox_dpath
  import mbox_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strb,
  input  logic [DATA_W-1:0]  busWdata,
  output logic [DATA_W-1:0]  busRdata,
  output logic [NUM_CH-1:0]  irq
);
  localparam int FLAG_BIT = DATA_W - 1;
  localparam logic [DATA_W-1:0] SLOT_MASK = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] rdTerm [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : gCh
    logic [DATA_W-1:0] status, statusNext;

    always_comb begin
      statusNext = status;
      if (strb.setEn[c]) statusNext = statusNext | (busWdata & SLOT_MASK);
      if (strb.clrEn[c]) statusNext = statusNext & ~busWdata;
      if (strb.nsHit[c]) statusNext[FLAG_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
      if (!rstN) status <= '0;
      else       status <= statusNext;
    end

    assign irq[c]    = |status;
    assign rdTerm[c] = strb.rdStat[c] ? status : '0;
  end

  always_comb begin
    busRdata = '0;
    for (int c = 0; c < NUM_CH; c++) busRdata = busRdata | rdTerm[c];
  end
endmodule

// File: rtl/mbox_doorbell.sv
module mbox_doorbell
  import mbox_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter int          DATA_W    = 32,
  parameter logic [11:0] CH_BASE   = 12'h200,
  parameter logic [11:0] CH_STRIDE = 12'h100
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic              busSecure,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqToApp,
  output logic              irqToCtl
);
  ctrlStrobes_t      strb;
  logic [NUM_CH-1:0] irq;

  mbox_ctrl #(.ADDR_W(ADDR_W), .CH_BASE(CH_BASE), .CH_STRIDE(CH_STRIDE)) uCtrl (
    .busSel(busSel), .busWrite(busWrite), .busSecure(busSecure),
    .busAddr(busAddr), .strb(strb)
  );

  mbox_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .busWdata(busWdata),
    .busRdata(busRdata), .irq(irq)
  );

  assign irqToApp = irq[0];
  assign irqToCtl = irq[1];
endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic              busSecure,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqToApp,
  input logic              irqToCtl
);
  logic inCh0, mapped, setOrClr;
  assign inCh0    = (busAddr == 12'h200) || (busAddr == 12'h208) || (busAddr == 12'h210);
  assign setOrClr = (busAddr == 12'h208) || (busAddr == 12'h210) ||
                    (busAddr == 12'h308) || (busAddr == 12'h310);
  assign mapped   = inCh0 || (busAddr == 12'h300) || setOrClr;

  // R2
  set_raises_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWrite && busSecure && busAddr == 12'h208 && busWdata[DATA_W-2:0] != '0
    |=> irqToApp);

  // R5
  nonsec_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busSecure && inCh0 |=> irqToApp);

  // R6
  nonsec_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && !busSecure |-> busRdata == '0);

  // R9
  setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWrite && setOrClr |-> busRdata == '0);

  // R9
  unmapped_no_effect_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !mapped |=> $stable(irqToApp) && $stable(irqToCtl));

  // R1
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> busRdata == '0);
endmodule

bind mbox_doorbell mbox_doorbell_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busSecure(busSecure), .busAddr(busAddr), .busWdata(busWdata),
  .busRdata(busRdata), .irqToApp(irqToApp), .irqToCtl(irqToCtl)
);

// File: tb/mbox_doorbell_test.sv
module mbox_doorbell_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0, busSecure = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqToApp, irqToCtl;
  int          nTests = 0, nFail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mbox_doorbell uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busSecure(busSecure), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqToApp(irqToApp), .irqToCtl(irqToCtl)
  );

  // {req[7:0], wr, sec, addr[11:0], wdata[31:0], expRd[31:0], irqA, irqC}
  localparam int NV = 24;
  localparam logic [87:0] VEC [NV] = '{
    {8'd1,  1'b0,1'b1,12'h200,32'h0,         32'h0,         1'b0,1'b0}, // R1
    {8'd1,  1'b0,1'b1,12'h300,32'h0,         32'h0,         1'b0,1'b0}, // R1
    {8'd2,  1'b1,1'b1,12'h208,32'h0000_0005, 32'h0,         1'b1,1'b0}, // R2
    {8'd2,  1'b0,1'b1,12'h200,32'h0,         32'h0000_0005, 1'b1,1'b0}, // R2
    {8'd2,  1'b1,1'b1,12'h208,32'h0,         32'h0,         1'b1,1'b0}, // R2 zeros
    {8'd2,  1'b0,1'b1,12'h200,32'h0,         32'h0000_0005, 1'b1,1'b0}, // R2
    {8'd4,  1'b1,1'b1,12'h308,32'h8000_0002, 32'h0,         1'b1,1'b1}, // R4
    {8'd4,  1'b0,1'b1,12'h300,32'h0,         32'h0000_0002, 1'b1,1'b1}, // R4
    {8'd10, 1'b0,1'b1,12'h200,32'h0,         32'h0000_0005, 1'b1,1'b1}, // R10
    {8'd3,  1'b1,1'b1,12'h210,32'h0000_0001, 32'h0,         1'b1,1'b1}, // R3
    {8'd3,  1'b0,1'b1,12'h200,32'h0,         32'h0000_0004, 1'b1,1'b1}, // R3
    {8'd9,  1'b0,1'b1,12'h208,32'h0,         32'h0,         1'b1,1'b1}, // R9
    {8'd9,  1'b0,1'b1,12'h310,32'h0,         32'h0,         1'b1,1'b1}, // R9
    {8'd8,  1'b1,1'b1,12'h310,32'h0000_0002, 32'h0,         1'b1,1'b0}, // R8
    {8'd8,  1'b1,1'b1,12'h210,32'h0000_0004, 32'h0,         1'b0,1'b0}, // R8
    {8'd5,  1'b1,1'b0,12'h208,32'h0000_0001, 32'h0,         1'b1,1'b0}, // R5
    {8'd5,  1'b0,1'b1,12'h200,32'h0,         32'h8000_0000, 1'b1,1'b0}, // R5
    {8'd6,  1'b0,1'b0,12'h300,32'h0,         32'h0,         1'b1,1'b1}, // R6
    {8'd6,  1'b0,1'b1,12'h300,32'h0,         32'h8000_0000, 1'b1,1'b1}, // R6
    {8'd7,  1'b1,1'b1,12'h310,32'h8000_0000, 32'h0,         1'b1,1'b0}, // R7
    {8'd7,  1'b1,1'b1,12'h210,32'h8000_0000, 32'h0,         1'b0,1'b0}, // R7
    {8'd9,  1'b1,1'b1,12'h100,32'hFFFF_FFFF, 32'h0,         1'b0,1'b0}, // R9
    {8'd9,  1'b0,1'b1,12'h204,32'h0,         32'h0,         1'b0,1'b0}, // R9
    {8'd9,  1'b1,1'b0,12'h204,32'hFFFF_FFFF, 32'h0,         1'b0,1'b0}  // R9
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive at negedge, check read data mid-cycle, check irqs just after the sampling edge.
  task automatic access(input int req, input logic wr, input logic sec, input logic [11:0] a,
                        input logic [31:0] wd, input logic [31:0] expRd,
                        input logic expA, input logic expC);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busSecure = sec; busAddr = a; busWdata = wd;
    #1;
    if (!wr) check(req, "rdata", busRdata, expRd);
    @(posedge clk);
    #1;
    busSel = 1'b0; busWrite = 1'b0;
    check(req, "irqToApp", {31'b0, irqToApp}, {31'b0, expA});
    check(req, "irqToCtl", {31'b0, irqToCtl}, {31'b0, expC});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check(1, "irqToApp at reset", {31'b0, irqToApp}, 32'h0);
    check(1, "irqToCtl at reset", {31'b0, irqToCtl}, 32'h0);
    @(negedge clk); rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [87:0] v;
      v = VEC[i];
      access(int'(v[87:80]), v[79], v[78], v[77:66], v[65:34], v[33:2], v[1], v[0]);
    end

    // R4: every slot settable, bit 31 dropped
    access(4, 1'b1, 1'b1, 12'h208, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
    access(4, 1'b0, 1'b1, 12'h200, 32'h0, 32'h7FFF_FFFF, 1'b1, 1'b0);
    access(3, 1'b1, 1'b1, 12'h210, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0);

    // R7 and R3 in one cycle: flag and a slot cleared together
    access(2, 1'b1, 1'b1, 12'h208, 32'h0000_0003, 32'h0, 1'b1, 1'b0);
    access(5, 1'b1, 1'b0, 12'h210, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b0);
    access(7, 1'b0, 1'b1, 12'h200, 32'h0, 32'h8000_0003, 1'b1, 1'b0);
    access(7, 1'b1, 1'b1, 12'h210, 32'h8000_0001, 32'h0, 1'b1, 1'b0);
    access(7, 1'b0, 1'b1, 12'h200, 32'h0, 32'h0000_0002, 1'b1, 1'b0);

    // R1: reset in mid-run clears everything
    access(2, 1'b1, 1'b1, 12'h308, 32'h0000_0010, 32'h0, 1'b1, 1'b1);
    @(negedge clk); rstN = 1'b0;
    @(posedge clk); #1;
    check(1, "irqToApp after reset", {31'b0, irqToApp}, 32'h0);
    check(1, "irqToCtl after reset", {31'b0, irqToCtl}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    access(1, 1'b0, 1'b1, 12'h300, 32'h0, 32'h0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      nTests++; nFail++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule